// File: doc/BRIEF.md
# Jitter-Attenuating Elastic Bit Buffer

This block sits behind a line receiver and absorbs phase wander between a jittered recovered bit stream and a smoothed output bit stream. Bits arrive on an input strobe and leave on an output strobe, both qualified against a single system clock. The usable depth is picked at run time from three sizes. After every start-up the read side is held half a depth behind the write side, so a steady stream sees a fixed latency of half the chosen depth.

When the fill level reaches a bound, the block records a slip: it raises a sticky flag and re-centres its pointers so data keeps moving. A guard-band option asks the external clock generator to run faster when the buffer is nearly full and slower when it is nearly empty. The guard band widens with depth. With the attenuator disabled, input bits pass straight to the output and the buffer stays idle.

Top module: `jitter_elastic_buf`

## Requirements
- R1: `depth_sel` picks the depth: 0 gives 32 bits, 1 gives 64 bits, and 2 or 3 give 128 bits. The guard band is 2 bits for 32, 3 bits for 64 and 4 bits for 128.
- R2: After a re-centre, input and output strobes may be given together on every cycle. In that case `out_bit` after the n-th paired strobe equals the `in_bit` of paired strobe n minus half the depth, for any n of at least half the depth.
- R3: An input strobe without an output strobe while the buffer holds a full depth is an overflow. The write is dropped, the fill returns to half depth, and `slip_flag` reads 1 after that clock edge.
- R4: An output strobe while the buffer is empty is an underflow. The read is dropped, the fill returns to half depth, and `slip_flag` reads 1 after that clock edge.
- R5: `slip_flag` stays set until a cycle with `slip_clr` high clears it. If a slip and a clear happen in the same cycle, the flag stays set.
- R6: `irq` is high exactly when `slip_flag` and `irq_en` are both high.
- R7: With `limit_en` and `atten_en` high, `speed_up` is high while the fill is at least the depth minus the guard band.
- R8: With `limit_en` and `atten_en` high, `slow_down` is high while the fill is at most the guard band. `speed_up` and `slow_down` are never high together.
- R9: With `atten_en` low, `out_bit` follows `in_bit` in the same cycle. Strobes then cause no slip and no rate request, and the buffer re-centres.
- R10: A change of `depth_sel` re-centres the buffer to half of the new depth in the following clock edge, and strobes in that cycle are ignored.
- R11: After reset, `slip_flag`, `irq`, `speed_up` and `slow_down` are 0, and the buffered output bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| atten_en | input | 1 | 1 uses the buffer, 0 bypasses it |
| depth_sel | input | 2 | Depth select code (R1) |
| limit_en | input | 1 | Enables rate requests |
| irq_en | input | 1 | Interrupt mask |
| slip_clr | input | 1 | Write-one-to-clear pulse for the slip flag |
| in_stb | input | 1 | Input bit strobe |
| in_bit | input | 1 | Jittered input bit |
| out_stb | input | 1 | Output bit strobe |
| out_bit | output | 1 | Smoothed output bit |
| speed_up | output | 1 | Near-full request to the clock generator |
| slow_down | output | 1 | Near-empty request to the clock generator |
| slip_flag | output | 1 | Sticky overflow/underflow flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its default address width of 7, so every depth code exists, including the duplicate code for 128. For each code, single-sided strobes step the fill through every level from the centre up to the overflow and from the centre down to the underflow. This checks each guard-band edge and both slip paths at every depth. Paired-strobe runs longer than each depth check the half-depth latency bit by bit. Separate sequences cover a depth change partway through a run, a slip and a clear landing in the same cycle, and bypass with strobes far beyond the largest depth.

// File: rtl/jeb_pkg.sv
package jeb_pkg;

  // Depth code to size step: codes 2 and 3 both map to the largest depth.
  function automatic int unsigned sel_step(input logic [1:0] sel);
    return (sel == 2'b11) ? 32'd2 : {30'd0, sel};
  endfunction

  // Depth in bits for a code, with max_log the log2 of the largest depth.
  function automatic int unsigned depth_of(input logic [1:0] sel, input int unsigned max_log);
    return 32'd1 << (max_log - 32'd2 + sel_step(sel));
  endfunction

  // Distance from a bound at which a rate request starts.
  function automatic int unsigned guard_of(input logic [1:0] sel);
    return 32'd2 + sel_step(sel);
  endfunction

endpackage

// File: rtl/jeb_ptr_ctrl.sv
module jeb_ptr_ctrl
  import jeb_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [1:0]        depth_sel,
  input  logic              wr_req,
  input  logic              rd_req,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic [ADDR_W-1:0] wptr,
  output logic [ADDR_W-1:0] rptr,
  output logic [ADDR_W:0]   fill,
  output logic              slip_evt,
  output logic              reinit
);
  localparam int unsigned FILL_W = ADDR_W + 1;

  logic [1:0]        sel_q;
  logic [FILL_W-1:0] depth_w;
  logic [FILL_W-1:0] half_w;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] half_a;
  logic              full;
  logic              empty;
  logic              ovf_evt;
  logic              unf_evt;
  logic              run;

  assign depth_w = FILL_W'(depth_of(depth_sel, ADDR_W));
  assign half_w  = depth_w >> 1;
  assign mask    = ADDR_W'(depth_w - FILL_W'(1));
  assign half_a  = ADDR_W'(half_w);

  assign reinit  = !active || (depth_sel != sel_q);
  assign run     = !reinit;
  assign full    = (fill == depth_w);
  assign empty   = (fill == '0);

  assign ovf_evt  = run && wr_req && !rd_req && full;
  assign unf_evt  = run && rd_req && empty;
  assign slip_evt = ovf_evt || unf_evt;

  assign wr_ok = run && !slip_evt && wr_req;
  assign rd_ok = run && !slip_evt && rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 2'b00;
      wptr  <= ADDR_W'(depth_of(2'b00, ADDR_W) / 2);
      rptr  <= '0;
      fill  <= FILL_W'(depth_of(2'b00, ADDR_W) / 2);
    end else begin
      sel_q <= depth_sel;
      if (reinit) begin
        wptr <= half_a;
        rptr <= '0;
        fill <= half_w;
      end else if (slip_evt) begin
        rptr <= (wptr - half_a) & mask;
        fill <= half_w;
      end else begin
        if (wr_ok) wptr <= (wptr + ADDR_W'(1)) & mask;
        if (rd_ok) rptr <= (rptr + ADDR_W'(1)) & mask;
        case ({wr_ok, rd_ok})
          2'b10:   fill <= fill + FILL_W'(1);
          2'b01:   fill <= fill - FILL_W'(1);
          default: fill <= fill;
        endcase
      end
    end
  end

  // R1: the fill never exceeds the selected depth outside a re-centre cycle
  p_fill_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> fill <= depth_w);

  // R3/R4: pointer distance agrees with the fill count
  p_ptr_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ((ADDR_W'(wptr - rptr) & mask) == (ADDR_W'(fill) & mask)));

  // R4: a slip always lands on half depth
  p_slip_centre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slip_evt |=> fill == $past(half_w));

  // R10: a re-centre clears the read pointer and sets half-depth fill
  p_reinit_centre_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (rptr == '0) && (fill == $past(half_w)));

endmodule

// File: rtl/jeb_bit_store.sv
module jeb_bit_store #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              rd_ok,
  input  logic [ADDR_W-1:0] wptr,
  input  logic [ADDR_W-1:0] rptr,
  input  logic              din,
  output logic              dout_q
);
  localparam int unsigned CELLS = 1 << ADDR_W;

  logic [CELLS-1:0] cells;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells  <= '0;
      dout_q <= 1'b0;
    end else begin
      if (wr_ok) cells[wptr] <= din;
      if (rd_ok) dout_q <= cells[rptr];
    end
  end

  // R2: the output bit only changes on an accepted read
  p_dout_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> $stable(dout_q));

endmodule

// File: rtl/jeb_rate_req.sv
module jeb_rate_req
  import jeb_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [1:0]      depth_sel,
  input  logic [ADDR_W:0] fill,
  output logic            speed_up,
  output logic            slow_down
);
  localparam int unsigned FILL_W = ADDR_W + 1;

  logic [FILL_W-1:0] depth_w;
  logic [FILL_W-1:0] guard_w;
  logic              near_full;
  logic              near_empty;

  assign depth_w    = FILL_W'(depth_of(depth_sel, ADDR_W));
  assign guard_w    = FILL_W'(guard_of(depth_sel));
  assign near_full  = fill >= (depth_w - guard_w);
  assign near_empty = fill <= guard_w;

  assign speed_up  = enable && near_full;
  assign slow_down = enable && near_empty;

  // R8: the two requests never overlap
  p_req_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(speed_up && slow_down));

  // R7: a speed-up request means more than half the depth is filled
  p_speed_above_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    speed_up |-> fill > (depth_w >> 1));

endmodule

// File: rtl/jeb_slip_status.sv
module jeb_slip_status (
  input  logic clk,
  input  logic rst_n,
  input  logic slip_evt,
  input  logic slip_clr,
  input  logic irq_en,
  output logic slip_flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        slip_flag <= 1'b0;
    else if (slip_evt) slip_flag <= 1'b1;
    else if (slip_clr) slip_flag <= 1'b0;
  end

  assign irq = slip_flag && irq_en;

  // R3: every slip leaves the flag set
  p_slip_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slip_evt |=> slip_flag);

  // R5: without a clear, the flag keeps its value
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_flag && !slip_clr) |=> slip_flag);

endmodule

// File: rtl/jitter_elastic_buf.sv
module jitter_elastic_buf #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       atten_en,
  input  logic [1:0] depth_sel,
  input  logic       limit_en,
  input  logic       irq_en,
  input  logic       slip_clr,
  input  logic       in_stb,
  input  logic       in_bit,
  input  logic       out_stb,
  output logic       out_bit,
  output logic       speed_up,
  output logic       slow_down,
  output logic       slip_flag,
  output logic       irq
);
  logic              wr_ok;
  logic              rd_ok;
  logic [ADDR_W-1:0] wptr;
  logic [ADDR_W-1:0] rptr;
  logic [ADDR_W:0]   fill;
  logic              slip_evt;
  logic              reinit;
  logic              buf_bit;

  jeb_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (atten_en),
    .depth_sel (depth_sel),
    .wr_req    (in_stb),
    .rd_req    (out_stb),
    .wr_ok     (wr_ok),
    .rd_ok     (rd_ok),
    .wptr      (wptr),
    .rptr      (rptr),
    .fill      (fill),
    .slip_evt  (slip_evt),
    .reinit    (reinit)
  );

  jeb_bit_store #(.ADDR_W(ADDR_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ok  (wr_ok),
    .rd_ok  (rd_ok),
    .wptr   (wptr),
    .rptr   (rptr),
    .din    (in_bit),
    .dout_q (buf_bit)
  );

  jeb_rate_req #(.ADDR_W(ADDR_W)) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (limit_en && atten_en),
    .depth_sel (depth_sel),
    .fill      (fill),
    .speed_up  (speed_up),
    .slow_down (slow_down)
  );

  jeb_slip_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .slip_evt  (slip_evt),
    .slip_clr  (slip_clr),
    .irq_en    (irq_en),
    .slip_flag (slip_flag),
    .irq       (irq)
  );

  assign out_bit = atten_en ? buf_bit : in_bit;

  // R9: in bypass, strobes produce neither slips nor rate requests
  p_bypass_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !atten_en |-> (!slip_evt && !speed_up && !slow_down));

  // R10: in bypass the buffer is held in its re-centre state
  p_bypass_reinit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !atten_en |-> reinit);

endmodule

// File: tb/sim_jitter_elastic_buf.sv
module sim_jitter_elastic_buf;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       atten_en = 1'b0;
  logic [1:0] depth_sel = 2'b00;
  logic       limit_en = 1'b0;
  logic       irq_en = 1'b0;
  logic       slip_clr = 1'b0;
  logic       in_stb = 1'b0;
  logic       in_bit = 1'b0;
  logic       out_stb = 1'b0;
  logic       out_bit;
  logic       speed_up;
  logic       slow_down;
  logic       slip_flag;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        hist [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  jitter_elastic_buf u0 (
    .clk(clk), .rst_n(rst_n), .atten_en(atten_en), .depth_sel(depth_sel),
    .limit_en(limit_en), .irq_en(irq_en), .slip_clr(slip_clr),
    .in_stb(in_stb), .in_bit(in_bit), .out_stb(out_stb), .out_bit(out_bit),
    .speed_up(speed_up), .slow_down(slow_down), .slip_flag(slip_flag), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic int dep_of(input int sel);
    return (sel >= 2) ? 128 : (32 << sel);
  endfunction

  function automatic int grd_of(input int sel);
    return (sel >= 2) ? 4 : 2 + sel;
  endfunction

  task automatic recentre(input int sel);
    in_stb = 0; out_stb = 0;
    atten_en = 0; depth_sel = 2'(sel);
    step();
    atten_en = 1;
  endtask

  // R1, R3, R4, R5, R6, R7, R8: walk the fill through every level
  task automatic sweep_bounds(input int sel);
    int dep = dep_of(sel);
    int half = dep / 2;
    int g = grd_of(sel);
    recentre(sel);
    limit_en = 1; irq_en = 1;
    slip_clr = 1; step(); slip_clr = 0;
    chk("R5 clear", slip_flag, 1'b0);
    chk("R7 centre", speed_up, 1'b0);
    chk("R8 centre", slow_down, 1'b0);
    for (int n = 1; n <= half; n++) begin
      in_stb = 1; step();
      chk("R1 R7 near-full edge", speed_up, (half + n >= dep - g));
      chk("R8 not near empty", slow_down, 1'b0);
    end
    chk("R3 no slip at full", slip_flag, 1'b0);
    step();
    in_stb = 0;
    chk("R3 overflow flag", slip_flag, 1'b1);
    chk("R6 irq enabled", irq, 1'b1);
    chk("R3 recentred", speed_up, 1'b0);
    slip_clr = 1; irq_en = 0; step(); slip_clr = 0;
    chk("R5 cleared", slip_flag, 1'b0);
    for (int m = 1; m <= half; m++) begin
      out_stb = 1; step();
      chk("R1 R8 near-empty edge", slow_down, (half - m <= g));
      chk("R7 not near full", speed_up, 1'b0);
    end
    chk("R4 no slip at empty", slip_flag, 1'b0);
    step();
    out_stb = 0;
    chk("R4 underflow flag", slip_flag, 1'b1);
    chk("R6 irq masked", irq, 1'b0);
    chk("R4 recentred", slow_down, 1'b0);
  endtask

  // R2: paired strobes give half-depth latency
  task automatic latency(input int sel);
    int dep = dep_of(sel);
    int half = dep / 2;
    recentre(sel);
    limit_en = 0;
    slip_clr = 1; step(); slip_clr = 0;
    for (int n = 0; n < dep + 8; n++) begin
      in_bit = lfsr[0];
      hist[n] = lfsr[0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_stb = 1; out_stb = 1;
      step();
      if (n >= half) chk("R2 latency", out_bit, hist[n - half]);
    end
    in_stb = 0; out_stb = 0;
    chk("R2 no slip", slip_flag, 1'b0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 flag", slip_flag, 1'b0);
    chk("R11 irq", irq, 1'b0);
    chk("R11 speed_up", speed_up, 1'b0);
    chk("R11 slow_down", slow_down, 1'b0);
    atten_en = 1; step();
    chk("R11 output bit", out_bit, 1'b0);

    for (int s = 0; s < 4; s++) sweep_bounds(s);
    for (int s = 0; s < 3; s++) latency(s);

    // R10: depth change re-centres to the new half depth
    recentre(0);
    limit_en = 1;
    for (int i = 0; i < 10; i++) begin in_stb = 1; step(); end
    in_stb = 0; depth_sel = 2'd1; step();
    for (int i = 0; i < 28; i++) begin in_stb = 1; step(); end
    chk("R10 below guard after change", speed_up, 1'b0);
    step();
    chk("R10 guard reached at 61 of 64", speed_up, 1'b1);

    // R5: slip and clear together leave the flag set
    in_stb = 0; slip_clr = 1; step(); slip_clr = 0;
    chk("R5 pre-clear", slip_flag, 1'b0);
    for (int i = 0; i < 3; i++) begin in_stb = 1; step(); end
    chk("R5 full no slip", slip_flag, 1'b0);
    slip_clr = 1; step(); slip_clr = 0; in_stb = 0;
    chk("R5 set wins over clear", slip_flag, 1'b1);
    slip_clr = 1; step(); slip_clr = 0;
    chk("R5 clear alone", slip_flag, 1'b0);

    // R9: bypass
    atten_en = 0; limit_en = 1;
    in_bit = 1; #1;
    chk("R9 bypass high", out_bit, 1'b1);
    in_bit = 0; #1;
    chk("R9 bypass low", out_bit, 1'b0);
    for (int i = 0; i < 200; i++) begin in_stb = 1; step(); end
    in_stb = 0;
    chk("R9 no slip in bypass", slip_flag, 1'b0);
    chk("R9 no speed_up in bypass", speed_up, 1'b0);
    chk("R9 no slow_down in bypass", slow_down, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule